// File: doc/BRIEF.md
# Priority Pin Crossbar Assigner

This block decides which digital peripheral signal appears on which physical pin of a small device with three ports: two ports of eight pins and one of four. Software-facing logic presents peripheral enables, a slave-select mode for the serial peripheral interface, and one skip bit per pin. A load strobe captures them into registers, and the whole pin assignment is then recomputed combinationally from those registers.

The two UART lines sit on fixed pins. Every other enabled signal takes the lowest-numbered pin that is free, in a fixed priority order of signals. The priority order is: serial clock, serial data in, serial data out, slave select, SMBus data, SMBus clock, comparator output, comparator asynchronous output, system clock output, three capture/compare outputs, counter input, timer 0 input and timer 1 input. A pin whose skip bit is set is passed over. Skip bits are how pins used by analog or crystal functions are kept away from the crossbar. Pins left without a peripheral are general-purpose I/O.

For each pin the block reports a function code and a GPIO flag. For each signal it reports the pin it landed on and whether it was placed at all.

Top module: `pin_crossbar`

## Requirements
- R1: After reset every pin carries code 0, every GPIO flag is 1, no signal is placed and every signal pin index reads 0.
- R2: Inputs are captured only on a clock edge with `cfg_load` high, and the outputs reflect the captured configuration from the following cycle. Changing inputs while `cfg_load` is low has no effect on any output.
- R3: With the UART enabled, TX takes pin 4 (code 1) and RX takes pin 5 (code 2). Both are always placed, even if those pins are skipped.
- R4: With the UART enabled, pins 4 and 5 are excluded from the search for all other signals. With it disabled, pins 4 and 5 are ordinary candidates.
- R5: The searched signals are handled one after another in priority order, and each takes the lowest-indexed pin that is neither skipped, reserved, nor already taken. Signal k (0 = TX … 16 = T1) puts code k+1 on its pin.
- R6: A pin whose skip bit is set carries code 0, except a fixed UART pin while the UART is enabled.
- R7: The SMBus enable requests both SDA (code 7) and SCL (code 8), with SDA ahead of SCL in the search.
- R8: The SPI enable requests serial clock, data in and data out (codes 3, 4, 5). Slave select (code 6) is requested only when `spi_nss_mode` is not 2'b00; 2'b00 is 3-wire mode, in which it takes no pin.
- R9: `pca_cex_cnt` = n requests the first n capture/compare outputs (codes 12, 13, 14), for n from 0 to 3.
- R10: A requested signal that finds no free pin has its placed flag low and its pin index 0, and no pin carries its code.
- R11: A pin's GPIO flag is 1 exactly when its code is 0. The number of non-GPIO pins equals the number of placed signals.
- R12: Pin index p is bit p of {skip_p2, skip_p1, skip_p0}: port 0 is 0–7, port 1 is 8–15, and port 2 is 16–19 with only four skip bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Capture all configuration inputs on this edge |
| uart_en | input | 1 | Enable UART TX/RX pair |
| spi_en | input | 1 | Enable SPI clock and data lines |
| spi_nss_mode | input | 2 | Slave-select mode; 2'b00 is 3-wire |
| smbus_en | input | 1 | Enable SMBus SDA/SCL pair |
| cmp_en | input | 1 | Enable comparator output |
| cmp_async_en | input | 1 | Enable comparator asynchronous output |
| sysclk_en | input | 1 | Enable system clock output |
| pca_cex_cnt | input | 2 | Number of capture/compare outputs requested |
| pca_eci_en | input | 1 | Enable counter input |
| tmr0_en | input | 1 | Enable timer 0 input |
| tmr1_en | input | 1 | Enable timer 1 input |
| skip_p0 | input | 8 | Skip bits, port 0 |
| skip_p1 | input | 8 | Skip bits, port 1 |
| skip_p2 | input | 4 | Skip bits, port 2 |
| pin_sel | output | 100 | 5-bit code per pin, pin p at bits [5p+4:5p] |
| pin_gpio | output | 20 | 1 when the pin carries no peripheral |
| sig_pin | output | 85 | 5-bit pin index per signal, signal k at bits [5k+4:5k] |
| sig_placed | output | 17 | 1 when signal k was given a pin |

## Verification
The assertions assume that the fixed UART pins lie inside the pin range and are distinct, and that all configuration reaches the assigner only through the load registers. The skip rule is therefore checked against registered state and exempts the UART pins while the UART is on. The stimulus stays within these limits because it drives every field only at its port width and then pulses the load strobe. It draws sparse random skip masks so that long priority chains are placed, and adds directed dense masks that starve the tail of the order, empty port 0/1 masks, and stimulus with the strobe held low.

// File: rtl/pin_xbar_pkg.sv
// Package: signal numbering, code width and the captured peripheral
// configuration shared by the crossbar modules.
// Assumes the signal order below is the placement priority.
package pin_xbar_pkg;
    localparam int NSIG       = 17;
    localparam int SIG_W      = $clog2(NSIG + 1);
    localparam int NUM_CEX    = 3;

    localparam int SIG_TX     = 0;
    localparam int SIG_RX     = 1;
    localparam int SIG_SCK    = 2;
    localparam int SIG_MISO   = 3;
    localparam int SIG_MOSI   = 4;
    localparam int SIG_NSS    = 5;
    localparam int SIG_SDA    = 6;
    localparam int SIG_SCL    = 7;
    localparam int SIG_CMP    = 8;
    localparam int SIG_CMPA   = 9;
    localparam int SIG_SYSCLK = 10;
    localparam int SIG_CEX0   = 11;
    localparam int SIG_ECI    = 14;
    localparam int SIG_T0     = 15;
    localparam int SIG_T1     = 16;

    localparam logic [1:0] NSS_3WIRE = 2'b00;

    typedef struct packed {
        logic       uart;
        logic       spi;
        logic [1:0] nss_mode;
        logic       smb;
        logic       cmp;
        logic       cmp_async;
        logic       sysclk;
        logic [1:0] cex_cnt;
        logic       eci;
        logic       t0;
        logic       t1;
    } periph_cfg_t;
endpackage

// File: rtl/xbar_cfg_regs.sv
// Configuration holding registers. Captures peripheral enables and the
// per-pin skip mask when load is high; holds them otherwise.
// Assumes a synchronous active-low reset clears everything to disabled.
module xbar_cfg_regs
    import pin_xbar_pkg::*;
#(
    parameter int NPINS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  periph_cfg_t       cfg_d,
    input  logic [NPINS-1:0]  skip_d,
    output periph_cfg_t       cfg_q,
    output logic [NPINS-1:0]  skip_q
);
    // Capture the configuration on a load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            skip_q <= '0;
        end else if (load) begin
            cfg_q  <= cfg_d;
            skip_q <= skip_d;
        end
    end
endmodule

// File: rtl/xbar_req_decode.sv
// Request decoder: turns the captured peripheral configuration into one
// request bit per crossbar signal, in priority order.
// Assumes paired signals (UART, SMBus) are requested together.
module xbar_req_decode
    import pin_xbar_pkg::*;
(
    input  periph_cfg_t      cfg,
    output logic [NSIG-1:0]  req
);
    // Expand enables into per-signal requests.
    always_comb begin
        req            = '0;
        req[SIG_TX]    = cfg.uart;
        req[SIG_RX]    = cfg.uart;
        req[SIG_SCK]   = cfg.spi;
        req[SIG_MISO]  = cfg.spi;
        req[SIG_MOSI]  = cfg.spi;
        req[SIG_NSS]   = cfg.spi && (cfg.nss_mode != NSS_3WIRE);
        req[SIG_SDA]   = cfg.smb;
        req[SIG_SCL]   = cfg.smb;
        req[SIG_CMP]   = cfg.cmp;
        req[SIG_CMPA]  = cfg.cmp_async;
        req[SIG_SYSCLK]= cfg.sysclk;
        for (int c = 0; c < NUM_CEX; c++) begin
            req[SIG_CEX0 + c] = (int'(cfg.cex_cnt) > c);
        end
        req[SIG_ECI]   = cfg.eci;
        req[SIG_T0]    = cfg.t0;
        req[SIG_T1]    = cfg.t1;
    end
endmodule

// File: rtl/xbar_place_chain.sv
// Placement chain: UART lines go to fixed pins; every other requested
// signal, in priority order, takes the lowest pin not yet occupied.
// Occupancy starts as skip mask plus reserved UART pins.
// Assumes TX_PIN and RX_PIN are distinct and below NPINS.
module xbar_place_chain
    import pin_xbar_pkg::*;
#(
    parameter int NPINS  = 20,
    parameter int TX_PIN = 4,
    parameter int RX_PIN = 5,
    localparam int PIN_W = $clog2(NPINS)
) (
    input  logic [NSIG-1:0]        req,
    input  logic [NPINS-1:0]       skip,
    output logic [NSIG*NPINS-1:0]  grant,
    output logic [NSIG*PIN_W-1:0]  sig_pin,
    output logic [NSIG-1:0]        sig_placed
);
    localparam logic [NPINS-1:0] TX_BIT = NPINS'(1) << TX_PIN;
    localparam logic [NPINS-1:0] RX_BIT = NPINS'(1) << RX_PIN;

    logic [NPINS-1:0] occ [NSIG];

    assign occ[0] = skip | (req[SIG_TX] ? (TX_BIT | RX_BIT) : '0);

    for (genvar k = 0; k < NSIG; k++) begin : g_sig
        logic [NPINS-1:0] g;
        logic [PIN_W-1:0] idx;

        if (k == SIG_TX) begin : g_fixed_tx
            assign g = req[k] ? TX_BIT : '0;
        end else if (k == SIG_RX) begin : g_fixed_rx
            assign g = req[k] ? RX_BIT : '0;
        end else begin : g_search
            logic [NPINS-1:0] free;
            assign free = ~occ[k];
            assign g = req[k] ? (free & (~free + NPINS'(1))) : '0;
        end

        if (k < NSIG - 1) begin : g_next
            if (k <= SIG_RX) begin : g_pass
                assign occ[k+1] = occ[k];
            end else begin : g_mark
                assign occ[k+1] = occ[k] | g;
            end
        end

        // Encode the one-hot grant into a pin index.
        always_comb begin
            idx = '0;
            for (int p = 0; p < NPINS; p++) begin
                if (g[p]) idx = idx | PIN_W'(p);
            end
        end

        assign grant[k*NPINS +: NPINS]   = g;
        assign sig_pin[k*PIN_W +: PIN_W] = idx;
        assign sig_placed[k]             = |g;
    end
endmodule

// File: rtl/xbar_pin_map.sv
// Pin map: folds the per-signal grants into a function code per pin
// (0 = GPIO, k+1 = signal k) and a GPIO flag.
// Assumes at most one grant per pin, which the chain guarantees.
module xbar_pin_map
    import pin_xbar_pkg::*;
#(
    parameter int NPINS = 20
) (
    input  logic [NSIG*NPINS-1:0]  grant,
    output logic [NPINS*SIG_W-1:0] pin_sel,
    output logic [NPINS-1:0]       pin_gpio
);
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic [SIG_W-1:0] code;
        logic             busy;

        // Gather the code of whichever signal owns this pin.
        always_comb begin
            code = '0;
            busy = 1'b0;
            for (int k = 0; k < NSIG; k++) begin
                if (grant[k*NPINS + p]) begin
                    code = code | SIG_W'(k + 1);
                    busy = 1'b1;
                end
            end
        end

        assign pin_sel[p*SIG_W +: SIG_W] = code;
        assign pin_gpio[p]               = ~busy;
    end
endmodule

// File: rtl/pin_crossbar.sv
// Top: priority pin crossbar. Registers configuration on cfg_load and
// derives the full pin assignment combinationally from the registers.
// Pin p is bit p of {skip_p2, skip_p1, skip_p0}.
module pin_crossbar
    import pin_xbar_pkg::*;
#(
    parameter int P0_PINS = 8,
    parameter int P1_PINS = 8,
    parameter int P2_PINS = 4,
    parameter int TX_PIN  = 4,
    parameter int RX_PIN  = 5,
    localparam int NPINS  = P0_PINS + P1_PINS + P2_PINS,
    localparam int PIN_W  = $clog2(NPINS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_load,
    input  logic                   uart_en,
    input  logic                   spi_en,
    input  logic [1:0]             spi_nss_mode,
    input  logic                   smbus_en,
    input  logic                   cmp_en,
    input  logic                   cmp_async_en,
    input  logic                   sysclk_en,
    input  logic [1:0]             pca_cex_cnt,
    input  logic                   pca_eci_en,
    input  logic                   tmr0_en,
    input  logic                   tmr1_en,
    input  logic [P0_PINS-1:0]     skip_p0,
    input  logic [P1_PINS-1:0]     skip_p1,
    input  logic [P2_PINS-1:0]     skip_p2,
    output logic [NPINS*SIG_W-1:0] pin_sel,
    output logic [NPINS-1:0]       pin_gpio,
    output logic [NSIG*PIN_W-1:0]  sig_pin,
    output logic [NSIG-1:0]        sig_placed
);
    periph_cfg_t             cfg_d, cfg_q;
    logic [NPINS-1:0]        skip_d, skip_q;
    logic [NSIG-1:0]         req;
    logic [NSIG*NPINS-1:0]   grant;

    // Pack the configuration inputs for the holding registers.
    always_comb begin
        cfg_d.uart      = uart_en;
        cfg_d.spi       = spi_en;
        cfg_d.nss_mode  = spi_nss_mode;
        cfg_d.smb       = smbus_en;
        cfg_d.cmp       = cmp_en;
        cfg_d.cmp_async = cmp_async_en;
        cfg_d.sysclk    = sysclk_en;
        cfg_d.cex_cnt   = pca_cex_cnt;
        cfg_d.eci       = pca_eci_en;
        cfg_d.t0        = tmr0_en;
        cfg_d.t1        = tmr1_en;
    end

    assign skip_d = {skip_p2, skip_p1, skip_p0};

    xbar_cfg_regs #(.NPINS(NPINS)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cfg_load),
        .cfg_d  (cfg_d),
        .skip_d (skip_d),
        .cfg_q  (cfg_q),
        .skip_q (skip_q)
    );

    xbar_req_decode u_req (
        .cfg (cfg_q),
        .req (req)
    );

    xbar_place_chain #(
        .NPINS  (NPINS),
        .TX_PIN (TX_PIN),
        .RX_PIN (RX_PIN)
    ) u_chain (
        .req        (req),
        .skip       (skip_q),
        .grant      (grant),
        .sig_pin    (sig_pin),
        .sig_placed (sig_placed)
    );

    xbar_pin_map #(.NPINS(NPINS)) u_map (
        .grant    (grant),
        .pin_sel  (pin_sel),
        .pin_gpio (pin_gpio)
    );
endmodule

// File: rtl/pin_crossbar_checker.sv
// Checker for pin_crossbar: relates registered configuration to the
// pin-side and signal-side outputs. Attached by bind below.
module pin_crossbar_checker
    import pin_xbar_pkg::*;
#(
    parameter int NPINS  = 20,
    parameter int TX_PIN = 4,
    parameter int RX_PIN = 5,
    localparam int PIN_W = $clog2(NPINS)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_load,
    input logic                   uart_q,
    input logic [1:0]             nss_mode_q,
    input logic                   smb_q,
    input logic [NPINS-1:0]       skip_q,
    input logic [NPINS*SIG_W-1:0] pin_sel,
    input logic [NPINS-1:0]       pin_gpio,
    input logic [NSIG*PIN_W-1:0]  sig_pin,
    input logic [NSIG-1:0]        sig_placed
);
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(pin_sel) && $stable(sig_placed));

    assert_uart_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        uart_q |-> sig_placed[SIG_TX] && sig_placed[SIG_RX]
                   && sig_pin[SIG_TX*PIN_W +: PIN_W] == PIN_W'(TX_PIN)
                   && sig_pin[SIG_RX*PIN_W +: PIN_W] == PIN_W'(RX_PIN));

    assert_smb_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        smb_q && sig_placed[SIG_SCL] |-> sig_placed[SIG_SDA]
            && sig_pin[SIG_SDA*PIN_W +: PIN_W] < sig_pin[SIG_SCL*PIN_W +: PIN_W]);

    assert_nss_3wire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        nss_mode_q == NSS_3WIRE |-> !sig_placed[SIG_NSS]);

    assert_gpio_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~pin_gpio) == $countones(sig_placed));

    for (genvar k = 0; k < NSIG; k++) begin : g_sig_chk
        assert_unplaced_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !sig_placed[k] |-> sig_pin[k*PIN_W +: PIN_W] == '0);
        assert_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
            sig_placed[k] |-> pin_sel[sig_pin[k*PIN_W +: PIN_W]*SIG_W +: SIG_W] == SIG_W'(k + 1));
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin_chk
        assert_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
            skip_q[p] && !(uart_q && (p == TX_PIN || p == RX_PIN)) |-> pin_gpio[p]);
    end
endmodule

bind pin_crossbar pin_crossbar_checker #(
    .NPINS  (NPINS),
    .TX_PIN (TX_PIN),
    .RX_PIN (RX_PIN)
) u_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_load   (cfg_load),
    .uart_q     (cfg_q.uart),
    .nss_mode_q (cfg_q.nss_mode),
    .smb_q      (cfg_q.smb),
    .skip_q     (skip_q),
    .pin_sel    (pin_sel),
    .pin_gpio   (pin_gpio),
    .sig_pin    (sig_pin),
    .sig_placed (sig_placed)
);

// File: tb/pin_crossbar_test.sv
// Bench for pin_crossbar: directed corner cases plus seeded random
// configurations, compared with a bench-side placement model.
module pin_crossbar_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic        uart_en, spi_en, smbus_en, cmp_en, cmp_async_en, sysclk_en;
    logic        pca_eci_en, tmr0_en, tmr1_en;
    logic [1:0]  spi_nss_mode, pca_cex_cnt;
    logic [7:0]  skip_p0, skip_p1;
    logic [3:0]  skip_p2;
    logic [99:0] pin_sel;
    logic [19:0] pin_gpio;
    logic [84:0] sig_pin;
    logic [16:0] sig_placed;

    logic [99:0] exp_sel;
    logic [19:0] exp_gpio;
    logic [84:0] exp_pin;
    logic [16:0] exp_placed;

    int total = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pin_crossbar uut (.*);

    task automatic clear_inputs();
        {uart_en, spi_en, smbus_en, cmp_en, cmp_async_en, sysclk_en} = '0;
        {pca_eci_en, tmr0_en, tmr1_en} = '0;
        spi_nss_mode = 2'b00; pca_cex_cnt = 2'b00;
        skip_p0 = '0; skip_p1 = '0; skip_p2 = '0;
    endtask

    // Reference placement computed from the requirements.
    task automatic model();
        logic [19:0] occ;
        logic [16:0] rq;
        occ = {skip_p2, skip_p1, skip_p0};
        exp_sel = '0; exp_pin = '0; exp_placed = '0;
        rq = '0;
        rq[2] = spi_en; rq[3] = spi_en; rq[4] = spi_en;
        rq[5] = spi_en && spi_nss_mode != 2'b00;
        rq[6] = smbus_en; rq[7] = smbus_en;
        rq[8] = cmp_en; rq[9] = cmp_async_en; rq[10] = sysclk_en;
        rq[11] = pca_cex_cnt >= 1; rq[12] = pca_cex_cnt >= 2; rq[13] = pca_cex_cnt == 3;
        rq[14] = pca_eci_en; rq[15] = tmr0_en; rq[16] = tmr1_en;
        if (uart_en) begin
            occ[4] = 1'b1; occ[5] = 1'b1;
            exp_sel[20 +: 5] = 5'd1; exp_sel[25 +: 5] = 5'd2;
            exp_pin[0 +: 5] = 5'd4;  exp_pin[5 +: 5] = 5'd5;
            exp_placed[1:0] = 2'b11;
        end
        for (int k = 2; k < 17; k++) begin
            if (rq[k]) begin
                bit found = 0;
                for (int p = 0; p < 20; p++) begin
                    if (!found && !occ[p]) begin
                        found = 1; occ[p] = 1'b1;
                        exp_sel[p*5 +: 5] = 5'(k + 1);
                        exp_pin[k*5 +: 5] = 5'(p);
                        exp_placed[k] = 1'b1;
                    end
                end
            end
        end
        for (int p = 0; p < 20; p++) exp_gpio[p] = (exp_sel[p*5 +: 5] == 5'd0);
    endtask

    task automatic check(string rq, string what, logic [127:0] act, logic [127:0] expv);
        total++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, expv);
        end
    endtask

    task automatic check_all(string rq);
        check(rq, "pin_sel", 128'(pin_sel), 128'(exp_sel));
        check(rq, "pin_gpio", 128'(pin_gpio), 128'(exp_gpio));
        check(rq, "sig_pin", 128'(sig_pin), 128'(exp_pin));
        check(rq, "sig_placed", 128'(sig_placed), 128'(exp_placed));
    endtask

    // Strobe load for one edge; outputs are valid at the following negedge.
    task automatic load_cfg();
        @(negedge clk); cfg_load = 1'b1;
        @(negedge clk); cfg_load = 1'b0;
        model();
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        void'($urandom(32'h5A17));
        clear_inputs();
        uart_en = 1'b1; spi_en = 1'b1; skip_p1 = 8'hFF;
        repeat (3) @(negedge clk);
        // R1: reset state, inputs ignored until a load
        check("R1", "pin_sel", 128'(pin_sel), 128'(0));
        check("R1", "pin_gpio", 128'(pin_gpio), 128'(20'hFFFFF));
        check("R1", "sig_placed", 128'(sig_placed), 128'(0));
        check("R1", "sig_pin", 128'(sig_pin), 128'(0));
        rst_n = 1'b1;

        // R2: load, then change inputs without a strobe
        clear_inputs(); uart_en = 1'b1; spi_en = 1'b1;
        load_cfg(); check_all("R2");
        smbus_en = 1'b1; skip_p0 = 8'hFF; uart_en = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R2");
        load_cfg(); check_all("R2");

        // R3: UART pins fixed even when skipped
        clear_inputs(); uart_en = 1'b1; skip_p0 = 8'h30;
        load_cfg(); check_all("R3");
        check("R3", "tx pin", 128'(sig_pin[0 +: 5]), 128'(4));
        check("R3", "rx code", 128'(pin_sel[25 +: 5]), 128'(2));

        // R4: reserved pins with UART on; free with UART off
        clear_inputs(); uart_en = 1'b1; spi_en = 1'b1; spi_nss_mode = 2'b01; smbus_en = 1'b1;
        load_cfg(); check_all("R4");
        check("R4", "sda pin", 128'(sig_pin[30 +: 5]), 128'(6));
        uart_en = 1'b0;
        load_cfg(); check_all("R4");
        check("R4", "sda pin", 128'(sig_pin[30 +: 5]), 128'(4));

        // R6: skipped low pins stay GPIO
        clear_inputs(); spi_en = 1'b1; skip_p0 = 8'h0F;
        load_cfg(); check_all("R6");
        check("R6", "sck pin", 128'(sig_pin[10 +: 5]), 128'(4));
        check("R6", "pins0-3", 128'(pin_gpio[3:0]), 128'(4'hF));

        // R8: slave select only outside 3-wire mode
        clear_inputs(); spi_en = 1'b1; spi_nss_mode = 2'b00;
        load_cfg(); check_all("R8");
        check("R8", "nss placed", 128'(sig_placed[5]), 128'(0));
        spi_nss_mode = 2'b10;
        load_cfg(); check_all("R8");
        check("R8", "nss pin", 128'(sig_pin[25 +: 5]), 128'(3));

        // R9: capture/compare count
        clear_inputs(); pca_cex_cnt = 2'd2;
        load_cfg(); check_all("R9");
        check("R9", "cex placed", 128'(sig_placed[13:11]), 128'(3'b011));

        // R10: starvation of the third SPI line
        clear_inputs(); spi_en = 1'b1; skip_p0 = 8'hFC; skip_p1 = 8'hFF; skip_p2 = 4'hF;
        load_cfg(); check_all("R10");
        check("R10", "mosi placed", 128'(sig_placed[4]), 128'(0));
        check("R10", "mosi pin", 128'(sig_pin[20 +: 5]), 128'(0));

        // R7: SMBus with a single free pin gets SDA only
        clear_inputs(); smbus_en = 1'b1; skip_p0 = 8'hFF; skip_p1 = 8'hFF; skip_p2 = 4'h7;
        load_cfg(); check_all("R7");
        check("R7", "sda/scl placed", 128'(sig_placed[7:6]), 128'(2'b01));

        // R12: port 2 indexing
        clear_inputs(); tmr0_en = 1'b1; tmr1_en = 1'b1; skip_p0 = 8'hFF; skip_p1 = 8'hFF; skip_p2 = 4'h7;
        load_cfg(); check_all("R12");
        check("R12", "t0 pin", 128'(sig_pin[75 +: 5]), 128'(19));
        skip_p2 = 4'h0; tmr1_en = 1'b0;
        load_cfg();
        check("R12", "t0 pin", 128'(sig_pin[75 +: 5]), 128'(16));

        // R5 / R11: random configurations
        for (int i = 0; i < 300; i++) begin
            {uart_en, spi_en, smbus_en, cmp_en, cmp_async_en, sysclk_en} = 6'($urandom);
            {pca_eci_en, tmr0_en, tmr1_en} = 3'($urandom);
            spi_nss_mode = 2'($urandom); pca_cex_cnt = 2'($urandom);
            if (i % 4 == 0) begin
                skip_p0 = 8'($urandom); skip_p1 = 8'($urandom); skip_p2 = 4'($urandom);
            end else begin
                skip_p0 = 8'($urandom & $urandom & $urandom);
                skip_p1 = 8'($urandom & $urandom);
                skip_p2 = 4'($urandom & $urandom);
            end
            load_cfg();
            check("R5", "pin_sel", 128'(pin_sel), 128'(exp_sel));
            check("R11", "pin_gpio", 128'(pin_gpio), 128'(exp_gpio));
            check("R5", "sig_pin", 128'(sig_pin), 128'(exp_pin));
            check("R10", "sig_placed", 128'(sig_placed), 128'(exp_placed));
        end

        done = 1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end
endmodule